// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit CPU bus and two external memories: a large ROM and a banked RAM. A CPU write anywhere in the lower half of the address space (0x0000–0x7FFF) does not reach the ROM. Instead, it is decoded as a write to one of four small control registers:

- a RAM enable,
- a 5-bit low ROM bank number,
- a 2-bit upper bank number,
- a mode bit.

From these registers, the block forms physical addresses for three CPU windows:

- the fixed ROM window at 0x0000–0x3FFF,
- the switchable ROM window at 0x4000–0x7FFF,
- the 8 KiB RAM window at 0xA000–0xBFFF.

It also gates the RAM chip enable and write enable, and returns 0xFF on RAM-window reads while RAM is disabled.

A static configuration input, `multicart`, narrows the low-bank field from 5 bits to 4. The upper bank then lands on 16-bank boundaries, which suits ROM images that pack several smaller images. The ROM and RAM sizes are parameters, given as log2 of the bank count. Bank numbers that exceed the ROM wrap around. All outputs are registered: each one reflects the CPU address of the previous cycle and the bank state from before any write in that same cycle.

Top module: `bankctl_top`

## Requirements
- R1: After reset the low bank is 1, the upper bank and mode are 0 and RAM is disabled, so the switchable window maps to ROM bank 1, the fixed window maps to bank 0 and RAM-window reads return 0xFF with `ram_ce` low.
- R2: A write with address bits 15:13 = 000 and data 0x0A enables RAM. The same write with data 0x00 disables RAM. Any other data value leaves the enable unchanged.
- R3: A write with address bits 15:13 = 001 loads the low bank from data bits 4:0. A loaded value of zero becomes one, and only then is the stride mask applied.
- R4: The switchable window bank is (upper << S) | (low & (2^S − 1)). S is 5 when `multicart` is 0 and 4 when it is 1.
- R5: A write with address bits 15:13 = 010 loads the upper bank from data bits 1:0. A write with address bits 15:13 = 011 loads the mode from data bit 0.
- R6: With mode 1, the fixed window uses bank (upper << S) and the RAM bank is upper, masked to the RAM bank count. With mode 0, both of these banks are 0.
- R7: ROM bank numbers are masked with (ROM bank count − 1). A switchable bank whose unmasked number is out of range and masks to 0 is replaced by bank 1. An unmasked 0 stays 0.
- R8: `ram_ce` and `ram_we` assert only for RAM-window accesses while RAM is enabled. `ram_bus_data` returns `ram_rdata` for an enabled RAM read and 0xFF in every other case.
- R9: Writes with address bit 15 set change no bank state.
- R10: One cycle after a CPU cycle, `rom_addr` is {bank, addr[13:0]} for an address below 0x8000 and holds its value otherwise. Likewise, `ram_addr` is {RAM bank, addr[12:0]} for a RAM-window address and holds otherwise. A register write affects addresses from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| multicart | input | 1 | Selects the 4-bit low-bank stride |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| ram_rdata | input | 8 | Data from the external RAM |
| rom_addr | output | ROM_BANKS_LOG2+14 | ROM physical address |
| ram_addr | output | RAM_BANKS_LOG2+13 | RAM physical address |
| ram_ce | output | 1 | RAM chip enable |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_bus_data | output | 8 | Read data returned for the RAM window |

## Verification
The assertions check the following on every cycle:
- the stored low bank is never zero,
- unrecognised enable values and writes above 0x7FFF leave the state untouched,
- `ram_ce` never asserts unless RAM was enabled,
- a write enable always comes with a chip enable,
- the fixed window stays on bank 0 in mode 0.

Only the bench scenarios can show the following:
- the exact bank arithmetic under both strides,
- the wrap and force-to-one corner cases,
- the RAM bank selection by mode,
- the one-cycle address timing.

The bench shows these by comparing every output against a model after directed and random register sequences.

// File: rtl/bankctl_pkg.sv
package bankctl_pkg;
  localparam int LOW_W         = 5;
  localparam int UP_W          = 2;
  localparam int STRIDE_NORMAL = 5;
  localparam int STRIDE_MULTI  = 4;
  localparam int FULL_W        = UP_W + STRIDE_NORMAL;
  localparam logic [7:0] KEY_RAM_ON  = 8'h0A;
  localparam logic [7:0] KEY_RAM_OFF = 8'h00;
  localparam logic [7:0] OPEN_BUS    = 8'hFF;

  typedef enum logic [1:0] {
    SEL_RAMEN = 2'd0,
    SEL_LOW   = 2'd1,
    SEL_UPPER = 2'd2,
    SEL_MODE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             ram_en;
    logic [LOW_W-1:0] low;
    logic [UP_W-1:0]  upper;
    logic             mode;
  } bank_state_t;
endpackage

// File: rtl/bankctl_regs.sv
module bankctl_regs
  import bankctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_stb,
  input  logic [2:0]  addr_hi,
  input  logic [7:0]  wdata,
  output bank_state_t state
);
  bank_state_t      st_q;
  reg_sel_e         sel;
  logic             ctl_wr;
  logic [LOW_W-1:0] low_next;

  assign sel    = reg_sel_e'(addr_hi[1:0]);
  assign ctl_wr = wr_stb && !addr_hi[2];

  always_comb begin
    low_next = wdata[LOW_W-1:0];
    if (low_next == '0) low_next = LOW_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '{ram_en: 1'b0, low: LOW_W'(1), upper: '0, mode: 1'b0};
    end else if (ctl_wr) begin
      case (sel)
        SEL_RAMEN: begin
          if (wdata == KEY_RAM_ON)       st_q.ram_en <= 1'b1;
          else if (wdata == KEY_RAM_OFF) st_q.ram_en <= 1'b0;
        end
        SEL_LOW:   st_q.low   <= low_next;
        SEL_UPPER: st_q.upper <= wdata[UP_W-1:0];
        SEL_MODE:  st_q.mode  <= wdata[0];
        default: ;
      endcase
    end
  end

  assign state = st_q;

  AST_LOW_NONZERO: assert property (@(posedge clk) disable iff (rst)
    st_q.low != '0); // R3

  AST_RAMEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && sel == SEL_RAMEN && wdata != KEY_RAM_ON && wdata != KEY_RAM_OFF)
      |=> $stable(st_q.ram_en)); // R2

  AST_HIGH_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && addr_hi[2]) |=> $stable(st_q)); // R9
endmodule

// File: rtl/bankctl_map.sv
module bankctl_map
  import bankctl_pkg::*;
#(
  parameter int ROM_BANKS_LOG2 = 5,
  parameter int RAM_BANKS_LOG2 = 2
) (
  input  bank_state_t               state,
  input  logic                      multicart,
  output logic [ROM_BANKS_LOG2-1:0] sw_bank,
  output logic [ROM_BANKS_LOG2-1:0] fix_bank,
  output logic [RAM_BANKS_LOG2-1:0] ram_bank
);
  logic [LOW_W-1:0]  low_mask;
  logic [LOW_W-1:0]  low_eff;
  logic [FULL_W-1:0] up_shift;
  logic [FULL_W-1:0] sw_full;
  logic [FULL_W-1:0] fix_full;

  always_comb begin
    if (multicart) begin
      low_mask = LOW_W'((1 << STRIDE_MULTI) - 1);
      up_shift = FULL_W'(state.upper) << STRIDE_MULTI;
    end else begin
      low_mask = LOW_W'((1 << STRIDE_NORMAL) - 1);
      up_shift = FULL_W'(state.upper) << STRIDE_NORMAL;
    end
    low_eff  = state.low & low_mask;
    sw_full  = up_shift | FULL_W'(low_eff);
    fix_full = state.mode ? up_shift : '0;
  end

  generate
    if (ROM_BANKS_LOG2 >= FULL_W) begin : g_rom_nowrap
      assign sw_bank  = ROM_BANKS_LOG2'(sw_full);
      assign fix_bank = ROM_BANKS_LOG2'(fix_full);
    end else begin : g_rom_wrap
      logic [ROM_BANKS_LOG2-1:0] sw_trunc;
      logic                      wrapped;
      logic                      unused_fix_hi;
      assign sw_trunc      = sw_full[ROM_BANKS_LOG2-1:0];
      assign wrapped       = |sw_full[FULL_W-1:ROM_BANKS_LOG2];
      assign sw_bank       = (wrapped && sw_trunc == '0) ? ROM_BANKS_LOG2'(1) : sw_trunc;
      assign fix_bank      = fix_full[ROM_BANKS_LOG2-1:0];
      assign unused_fix_hi = ^fix_full[FULL_W-1:ROM_BANKS_LOG2];
    end

    if (RAM_BANKS_LOG2 >= UP_W) begin : g_ram_full
      assign ram_bank = state.mode ? RAM_BANKS_LOG2'(state.upper) : '0;
    end else begin : g_ram_trunc
      logic unused_up_hi;
      assign ram_bank     = state.mode ? state.upper[RAM_BANKS_LOG2-1:0] : '0;
      assign unused_up_hi = ^state.upper[UP_W-1:RAM_BANKS_LOG2];
    end
  endgenerate
endmodule

// File: rtl/bankctl_out.sv
module bankctl_out
  import bankctl_pkg::*;
#(
  parameter int ROM_BANKS_LOG2 = 5,
  parameter int RAM_BANKS_LOG2 = 2,
  localparam int ROM_AW = ROM_BANKS_LOG2 + 14,
  localparam int RAM_AW = RAM_BANKS_LOG2 + 13
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [15:0]               cpu_addr,
  input  logic [7:0]                cpu_wdata,
  input  logic                      cpu_wr,
  input  logic                      cpu_rd,
  input  logic [7:0]                ram_rdata,
  input  logic                      ram_en,
  input  logic [ROM_BANKS_LOG2-1:0] sw_bank,
  input  logic [ROM_BANKS_LOG2-1:0] fix_bank,
  input  logic [RAM_BANKS_LOG2-1:0] ram_bank,
  output logic [ROM_AW-1:0]         rom_addr,
  output logic [RAM_AW-1:0]         ram_addr,
  output logic                      ram_ce,
  output logic                      ram_we,
  output logic [7:0]                ram_wdata,
  output logic [7:0]                ram_bus_data
);
  logic                      rom_win;
  logic                      ram_win;
  logic [ROM_BANKS_LOG2-1:0] rom_bank_sel;
  logic                      rd_hit_q;

  assign rom_win      = !cpu_addr[15];
  assign ram_win      = cpu_addr[15:13] == 3'b101;
  assign rom_bank_sel = cpu_addr[14] ? sw_bank : fix_bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr  <= '0;
      ram_addr  <= '0;
      ram_ce    <= 1'b0;
      ram_we    <= 1'b0;
      ram_wdata <= '0;
      rd_hit_q  <= 1'b0;
    end else begin
      if (rom_win) rom_addr <= {rom_bank_sel, cpu_addr[13:0]};
      if (ram_win) ram_addr <= {ram_bank, cpu_addr[12:0]};
      ram_ce   <= ram_win && ram_en && (cpu_rd || cpu_wr);
      ram_we   <= ram_win && ram_en && cpu_wr;
      rd_hit_q <= ram_win && ram_en && cpu_rd && !cpu_wr;
      if (cpu_wr) ram_wdata <= cpu_wdata;
    end
  end

  assign ram_bus_data = rd_hit_q ? ram_rdata : OPEN_BUS;

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ram_ce); // R8
endmodule

// File: rtl/bankctl_top.sv
module bankctl_top
  import bankctl_pkg::*;
#(
  parameter int ROM_BANKS_LOG2 = 5,
  parameter int RAM_BANKS_LOG2 = 2,
  localparam int ROM_AW = ROM_BANKS_LOG2 + 14,
  localparam int RAM_AW = RAM_BANKS_LOG2 + 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              multicart,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        ram_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_ce,
  output logic              ram_we,
  output logic [7:0]        ram_wdata,
  output logic [7:0]        ram_bus_data
);
  bank_state_t               state;
  logic [ROM_BANKS_LOG2-1:0] sw_bank;
  logic [ROM_BANKS_LOG2-1:0] fix_bank;
  logic [RAM_BANKS_LOG2-1:0] ram_bank;

  bankctl_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (cpu_wr),
    .addr_hi (cpu_addr[15:13]),
    .wdata   (cpu_wdata),
    .state   (state)
  );

  bankctl_map #(
    .ROM_BANKS_LOG2 (ROM_BANKS_LOG2),
    .RAM_BANKS_LOG2 (RAM_BANKS_LOG2)
  ) u_map (
    .state     (state),
    .multicart (multicart),
    .sw_bank   (sw_bank),
    .fix_bank  (fix_bank),
    .ram_bank  (ram_bank)
  );

  bankctl_out #(
    .ROM_BANKS_LOG2 (ROM_BANKS_LOG2),
    .RAM_BANKS_LOG2 (RAM_BANKS_LOG2)
  ) u_out (
    .clk          (clk),
    .rst          (rst),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_wr       (cpu_wr),
    .cpu_rd       (cpu_rd),
    .ram_rdata    (ram_rdata),
    .ram_en       (state.ram_en),
    .sw_bank      (sw_bank),
    .fix_bank     (fix_bank),
    .ram_bank     (ram_bank),
    .rom_addr     (rom_addr),
    .ram_addr     (ram_addr),
    .ram_ce       (ram_ce),
    .ram_we       (ram_we),
    .ram_wdata    (ram_wdata),
    .ram_bus_data (ram_bus_data)
  );

  AST_CE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    ram_ce |-> $past(state.ram_en)); // R8

  AST_FIXED_BANK0_MODE0: assert property (@(posedge clk) disable iff (rst)
    $past(cpu_addr[15:14] == 2'b00 && !state.mode) |-> rom_addr[ROM_AW-1:14] == '0); // R6
endmodule

// File: tb/bankctl_top_tb_top.sv
module bankctl_top_tb_top;
  localparam int ROM_BL    = 5;
  localparam int RAM_BL    = 2;
  localparam int ROM_BANKS = 1 << ROM_BL;
  localparam int RAM_BANKS = 1 << RAM_BL;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        multicart = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  ram_rdata = 8'h5A;
  logic [ROM_BL+13:0] rom_addr;
  logic [RAM_BL+12:0] ram_addr;
  logic        ram_ce, ram_we;
  logic [7:0]  ram_wdata, ram_bus_data;

  always #2.5 clk = ~clk;

  bankctl_top #(.ROM_BANKS_LOG2(ROM_BL), .RAM_BANKS_LOG2(RAM_BL)) dut_i (
    .clk(clk), .rst(rst), .multicart(multicart), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .ram_rdata(ram_rdata),
    .rom_addr(rom_addr), .ram_addr(ram_addr), .ram_ce(ram_ce), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_bus_data(ram_bus_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_en = 0, m_low = 1, m_up = 0, m_mode = 0, m_multi = 0;
  int exp_rom = 0, exp_ram = 0;

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, got, exp);
    end
  endtask

  function automatic int stride();
    return m_multi ? 4 : 5;
  endfunction

  function automatic int sw_bank();
    int lo = m_low & ((1 << stride()) - 1);
    int full = (m_up << stride()) | lo;
    int b = full & (ROM_BANKS - 1);
    if (full >= ROM_BANKS && b == 0) b = 1;
    return b;
  endfunction

  function automatic int fix_bank();
    return m_mode ? ((m_up << stride()) & (ROM_BANKS - 1)) : 0;
  endfunction

  function automatic int ram_bank();
    return m_mode ? (m_up & (RAM_BANKS - 1)) : 0;
  endfunction

  task automatic model_write(int a, int d);
    if (a < 16'h8000) begin
      case (a >> 13)
        0: begin if (d == 8'h0A) m_en = 1; else if (d == 0) m_en = 0; end
        1: begin m_low = d & 31; if (m_low == 0) m_low = 1; end
        2: m_up = d & 3;
        default: m_mode = d & 1;
      endcase
    end
  endtask

  task automatic set_multi(int v);
    @(negedge clk);
    multicart = v[0];
    m_multi = v;
  endtask

  // One CPU cycle with full output check against the model.
  task automatic step(int a, int d, int wr, int rd);
    int win, ece, ewe, ebus, rdv;
    rdv = $urandom & 8'hFF;
    @(negedge clk);
    cpu_addr = a[15:0]; cpu_wdata = d[7:0]; cpu_wr = wr[0]; cpu_rd = rd[0]; ram_rdata = rdv[7:0];
    win = ((a >> 13) == 5) ? 1 : 0;
    if (a < 16'h8000)
      exp_rom = (((a & 16'h4000) != 0 ? sw_bank() : fix_bank()) << 14) | (a & 16'h3FFF);
    if (win) exp_ram = (ram_bank() << 13) | (a & 16'h1FFF);
    ece  = (win && m_en && (rd || wr)) ? 1 : 0;
    ewe  = (win && m_en && wr) ? 1 : 0;
    ebus = (win && m_en && rd && !wr) ? rdv : 8'hFF;
    @(posedge clk); #1;
    chk((a & 16'h4000) != 0 ? "R4/R7/R10" : "R6/R10", "rom_addr", int'(rom_addr), exp_rom);
    chk("R6/R10", "ram_addr", int'(ram_addr), exp_ram);
    chk("R8", "ram_ce", int'(ram_ce), ece);
    chk("R8", "ram_we", int'(ram_we), ewe);
    chk("R8", "ram_bus_data", int'(ram_bus_data), ebus);
    if (ewe) chk("R8", "ram_wdata", int'(ram_wdata), d & 8'hFF);
    if (wr) model_write(a, d);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic wr_reg(int a, int d);
    step(a, d, 1, 0);
  endtask

  task automatic probe_sw(string req, int expbank);
    step(16'h4321, 0, 0, 0);
    chk(req, "switchable bank", int'(rom_addr) >> 14, expbank);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h00C0FFEE);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    step(16'h4000, 0, 0, 0);
    chk("R1", "reset switchable", int'(rom_addr), 1 << 14);
    step(16'h0123, 0, 0, 0);
    chk("R1", "reset fixed", int'(rom_addr), 16'h0123);
    step(16'hA010, 0, 0, 1);
    chk("R1", "reset ram_ce", int'(ram_ce), 0);
    chk("R1", "reset bus", int'(ram_bus_data), 8'hFF);

    // R2: enable keys
    wr_reg(16'h0000, 8'h0A);
    step(16'hA100, 0, 0, 1);
    chk("R2", "enabled ce", int'(ram_ce), 1);
    wr_reg(16'h1FFF, 8'h33);
    step(16'hB000, 0, 0, 1);
    chk("R2", "ignored key keeps enable", int'(ram_ce), 1);
    step(16'hA055, 8'hC3, 1, 0);
    chk("R8", "ram write strobe", int'(ram_we), 1);
    wr_reg(16'h0000, 8'h00);
    step(16'hA100, 0, 0, 1);
    chk("R2", "disabled ce", int'(ram_ce), 0);
    wr_reg(16'h0000, 8'h0B);
    step(16'hA100, 0, 0, 1);
    chk("R8", "disabled bus", int'(ram_bus_data), 8'hFF);

    // R3: low bank
    wr_reg(16'h2000, 8'h00);
    probe_sw("R3", 1);
    wr_reg(16'h3000, 8'hE3);
    probe_sw("R3", 3);
    set_multi(1);
    wr_reg(16'h2000, 8'h10);
    probe_sw("R3", 0);  // mask after zero substitution, unmasked 0 stays 0 (R7)

    // R4/R5/R7: upper bank, stride, wrap
    wr_reg(16'h4000, 8'hFD);  // upper = 1
    probe_sw("R5", 16);
    wr_reg(16'h4000, 8'h02);
    probe_sw("R7", 1);  // 32 wraps to 0, forced to 1
    set_multi(0);
    wr_reg(16'h2000, 8'h07);
    wr_reg(16'h4000, 8'h01);
    probe_sw("R7", 7);  // 39 wraps to 7
    set_multi(1);
    probe_sw("R4", 16 | 7);

    // R6: mode
    wr_reg(16'h6000, 8'hFF);
    step(16'h0042, 0, 0, 0);
    chk("R6", "fixed bank mode1", int'(rom_addr) >> 14, 16);
    wr_reg(16'h0000, 8'h0A);
    step(16'hA002, 0, 0, 1);
    chk("R6", "ram bank mode1", int'(ram_addr) >> 13, 1);
    wr_reg(16'h6000, 8'hFE);
    step(16'h0042, 0, 0, 0);
    chk("R6", "fixed bank mode0", int'(rom_addr) >> 14, 0);

    // R9: high writes ignored
    step(16'hA000, 8'h00, 1, 0);
    step(16'h8000, 8'h00, 1, 0);
    step(16'hE000, 8'h00, 1, 0);
    step(16'hA003, 0, 0, 1);
    chk("R9", "enable kept after high writes", int'(ram_ce), 1);
    probe_sw("R9", 16 | 7);

    // Random sweep, both strides and modes
    for (int i = 0; i < 1500; i++) begin
      int r = $urandom % 10;
      if (r == 0) set_multi($urandom & 1);
      else if (r <= 4) begin
        int d = $urandom & 8'hFF;
        if (r == 1) begin
          int k = $urandom % 3;
          d = (k == 0) ? 8'h0A : (k == 1) ? 8'h00 : d;
        end
        wr_reg(((r - 1) << 13) | ($urandom & 16'h1FFF), d);
      end else if (r <= 7) step($urandom & 16'h7FFF, 0, 0, 0);
      else step(16'hA000 | ($urandom & 16'h1FFF), $urandom & 8'hFF, (r == 9) ? 1 : 0, (r == 8) ? 1 : 0);
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R10 actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule